// File: doc/BRIEF.md
# Video Clamp and Gain Control Loop

This block closes the digital half of the black-level and amplitude control loops for an analog video front end. It watches two streams of 8-bit converter samples, one from the composite or luma channel and one from the chroma channel. From them it produces a clamp steering command for each channel's coupling capacitor and a 9-bit gain code for each of the two input amplifiers.

Clamping compares each sample against a fixed per-channel target code. It acts only while the back-porch clamp window is open. Gain is measured once per line at the sync bottom, inside the gain window. It moves by at most one code per line, with a tolerance band around the target. A full-scale luma sample forces the next step to be a decrease. Both loops stop while the vertical blanking flag is high.

A mode input chooses the gain source. With the mode low, both amplifiers take register-supplied codes. With the mode high, the luma amplifier is driven by the automatic loop. The chroma amplifier always takes its register code.

Top module: `vid_clamp_agc`

## Requirements
- R1: While reset is asserted, both clamp outputs are hold (code 00) and the automatic luma gain code is GAIN_INIT (default 256), visible on gain_y when agc_en is high.
- R2: When clamp_win is low or vblank is high at a clock edge, both clamp outputs are hold (00) after that edge.
- R3: When clamp_win is high and vblank is low at an edge, the luma clamp output after that edge is up (01) for a luma sample below 60, down (10) for a sample above 60, and hold (00) for a sample equal to 60.
- R4: Under the same gating, the chroma clamp output is up (01), down (10) or hold (00) for a chroma sample below, above or equal to 128.
- R5: With agc_en low, gain_y equals static_gain_y and gain_c equals static_gain_c. When agc_en is raised, the automatic code starts from the last static_gain_y value.
- R6: With agc_en high, gain_c still equals static_gain_c. gain_y changes only at the first clock edge at which gain_win is low after having been high, and then by at most one code.
- R7: The sync level is the minimum luma sample taken while gain_win is high. A minimum below SYNC_TGT-1 (default 15) lowers the gain by one. A minimum above SYNC_TGT+1 (default 17) raises it by one. A minimum from 15 to 17 leaves it unchanged.
- R8: A luma sample of 255 taken outside vertical blanking since the previous gain update forces the next update to lower the gain by one, whatever the sync level.
- R9: Samples taken while vblank is high are neither measured nor counted as peaks. A gain window that closes during vblank leaves the gain unchanged.
- R10: The automatic gain code saturates at 0 and at 511 and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_smp | input | 8 | Luma or composite converter sample |
| chroma_smp | input | 8 | Chroma converter sample |
| clamp_win | input | 1 | Back-porch clamp window |
| gain_win | input | 1 | Sync-bottom gain measurement window |
| vblank | input | 1 | Vertical blanking; freezes both loops |
| agc_en | input | 1 | 1: automatic luma gain, 0: static gains |
| static_gain_y | input | 9 | Register gain for the luma amplifier |
| static_gain_c | input | 9 | Register gain for the chroma amplifier |
| clamp_y | output | 2 | Luma clamp command: 00 hold, 01 up, 10 down |
| clamp_c | output | 2 | Chroma clamp command: 00 hold, 01 up, 10 down |
| gain_y | output | 9 | Luma amplifier gain code |
| gain_c | output | 9 | Chroma amplifier gain code |

## Verification
Clamp commands are registered, so each result appears one clock after the edge that takes the sample. The bench drives each table entry on a falling edge and reads the outputs one nanosecond after the next rising edge. The automatic gain is due at the first rising edge at which the gain window is seen low. The line task ends exactly there, and its checks also read the code one edge earlier to confirm it has not moved yet. The static gain paths are combinational, so they are checked in the same cycle they are driven.

// File: rtl/vca_pkg.sv
package vca_pkg;
   typedef enum logic [1:0] {
      CL_HOLD = 2'b00,
      CL_UP   = 2'b01,
      CL_DOWN = 2'b10
   } clamp_e;
endpackage

// File: rtl/vca_clamp_ch.sv
module vca_clamp_ch
   import vca_pkg::*;
#(
   parameter int DW     = 8,
   parameter int TARGET = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] smp,
   input  logic          win,
   input  logic          vblank,
   output clamp_e        clamp_q
);
   localparam logic [DW-1:0] TGT = DW'(TARGET);

   if (TARGET < 0 || TARGET >= (1 << DW)) begin : g_bad_target
      $error("clamp target outside sample range");
   end

   clamp_e clamp_d;

   always_comb begin
      clamp_d = CL_HOLD;
      if (win && !vblank) begin
         if (smp < TGT)      clamp_d = CL_UP;
         else if (smp > TGT) clamp_d = CL_DOWN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clamp_q <= CL_HOLD;
      else        clamp_q <= clamp_d;
   end

   // R2: gated off outside the window or in blanking
   p_clamp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!win || vblank) |=> (clamp_q == CL_HOLD));
   // R3 (luma) and R4 (chroma): below-target samples steer upward
   p_clamp_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (win && !vblank && smp < TGT) |=> (clamp_q == CL_UP));
   p_clamp_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win && !vblank && smp > TGT) |=> (clamp_q == CL_DOWN));
endmodule

// File: rtl/vca_sync_meas.sv
module vca_sync_meas #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] smp,
   input  logic          gain_win,
   input  logic          vblank,
   output logic          upd,
   output logic          peak_q,
   output logic [DW-1:0] min_q
);
   localparam logic [DW-1:0] SMP_MAX = {DW{1'b1}};

   logic win_d, meas_vld, win_fall, take;

   assign win_fall = win_d && !gain_win;
   assign take     = gain_win && !vblank;
   assign upd      = win_fall && !vblank && meas_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_d    <= 1'b0;
         meas_vld <= 1'b0;
         min_q    <= SMP_MAX;
         peak_q   <= 1'b0;
      end else begin
         win_d <= gain_win;
         if (win_fall) meas_vld <= 1'b0;
         else if (take) meas_vld <= 1'b1;
         if (take && (!meas_vld || smp < min_q)) min_q <= smp;
         if (!vblank && smp == SMP_MAX) peak_q <= 1'b1;
         else if (upd)                  peak_q <= 1'b0;
      end
   end

   // R9: a blanking sample never raises the peak flag
   p_no_peak_in_vblank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank && !peak_q) |=> !peak_q);
endmodule

// File: rtl/vca_gain_loop.sv
module vca_gain_loop #(
   parameter int DW        = 8,
   parameter int GW        = 9,
   parameter int SYNC_TGT  = 16,
   parameter int DEAD_BAND = 1,
   parameter int GAIN_INIT = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          agc_en,
   input  logic          vblank,
   input  logic [GW-1:0] static_gain,
   input  logic          upd,
   input  logic          peak,
   input  logic [DW-1:0] sync_min,
   output logic [GW-1:0] gain_q
);
   localparam logic [DW-1:0] LO       = DW'(SYNC_TGT - DEAD_BAND);
   localparam logic [DW-1:0] HI       = DW'(SYNC_TGT + DEAD_BAND);
   localparam logic [GW-1:0] GAIN_MAX = {GW{1'b1}};

   if (SYNC_TGT - DEAD_BAND < 1 || SYNC_TGT + DEAD_BAND > (1 << DW) - 2) begin : g_bad_band
      $error("sync target band outside sample range");
   end
   if (GAIN_INIT < 0 || GAIN_INIT >= (1 << GW)) begin : g_bad_init
      $error("initial gain outside code range");
   end

   logic step_dn, step_up;
   assign step_dn = peak || (sync_min < LO);
   assign step_up = !peak && (sync_min > HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gain_q <= GW'(GAIN_INIT);
      else if (!agc_en)  gain_q <= static_gain;
      else if (upd) begin
         if (step_dn && gain_q != '0)           gain_q <= gain_q - 1'b1;
         else if (step_up && gain_q != GAIN_MAX) gain_q <= gain_q + 1'b1;
      end
   end

   // R6: one code per update at most
   p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      agc_en |=> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1
                  || gain_q == $past(gain_q) - 1'b1));
   // R7: inside the tolerance band the code stays
   p_dead_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_en && upd && !peak && sync_min >= LO && sync_min <= HI) |=> $stable(gain_q));
   // R8: a peak forces a decrement
   p_peak_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_en && upd && peak && gain_q != '0) |=> (gain_q == $past(gain_q) - 1'b1));
   // R9: frozen during blanking
   p_vblank_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_en && vblank) |=> $stable(gain_q));
   // R10: no wrap at either end
   p_no_wrap_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_en && gain_q == '0) |=> (gain_q != GAIN_MAX));
   p_no_wrap_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_en && gain_q == GAIN_MAX) |=> (gain_q != '0));
endmodule

// File: rtl/vid_clamp_agc.sv
module vid_clamp_agc
   import vca_pkg::*;
#(
   parameter int DW        = 8,
   parameter int GW        = 9,
   parameter int Y_CLAMP   = 60,
   parameter int C_CLAMP   = 128,
   parameter int SYNC_TGT  = 16,
   parameter int DEAD_BAND = 1,
   parameter int GAIN_INIT = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] luma_smp,
   input  logic [DW-1:0] chroma_smp,
   input  logic          clamp_win,
   input  logic          gain_win,
   input  logic          vblank,
   input  logic          agc_en,
   input  logic [GW-1:0] static_gain_y,
   input  logic [GW-1:0] static_gain_c,
   output logic [1:0]    clamp_y,
   output logic [1:0]    clamp_c,
   output logic [GW-1:0] gain_y,
   output logic [GW-1:0] gain_c
);
   localparam int NCH = 2;

   logic [DW-1:0] smp_a [NCH];
   clamp_e        cl_a  [NCH];

   assign smp_a[0] = luma_smp;
   assign smp_a[1] = chroma_smp;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int TGT = (i == 0) ? Y_CLAMP : C_CLAMP;
      vca_clamp_ch #(.DW(DW), .TARGET(TGT)) u_clamp (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp     (smp_a[i]),
         .win     (clamp_win),
         .vblank  (vblank),
         .clamp_q (cl_a[i])
      );
   end

   assign clamp_y = cl_a[0];
   assign clamp_c = cl_a[1];

   logic          upd, peak;
   logic [DW-1:0] sync_min;
   logic [GW-1:0] auto_gain;

   vca_sync_meas #(.DW(DW)) u_meas (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (luma_smp),
      .gain_win (gain_win),
      .vblank   (vblank),
      .upd      (upd),
      .peak_q   (peak),
      .min_q    (sync_min)
   );

   vca_gain_loop #(
      .DW(DW), .GW(GW), .SYNC_TGT(SYNC_TGT),
      .DEAD_BAND(DEAD_BAND), .GAIN_INIT(GAIN_INIT)
   ) u_gain (
      .clk         (clk),
      .rst_n       (rst_n),
      .agc_en      (agc_en),
      .vblank      (vblank),
      .static_gain (static_gain_y),
      .upd         (upd),
      .peak        (peak),
      .sync_min    (sync_min),
      .gain_q      (auto_gain)
   );

   assign gain_y = agc_en ? auto_gain : static_gain_y;
   assign gain_c = static_gain_c;

   // R5/R6: chroma amplifier never leaves its register code
   p_chroma_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (gain_c == static_gain_c));
endmodule

// File: tb/tb_vid_clamp_agc.sv
module tb_vid_clamp_agc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] luma_smp = 8'd100, chroma_smp = 8'd128;
   logic       clamp_win = 1'b0, gain_win = 1'b0, vblank = 1'b0, agc_en = 1'b1;
   logic [8:0] static_gain_y = 9'd5, static_gain_c = 9'd77;
   logic [1:0] clamp_y, clamp_c;
   logic [8:0] gain_y, gain_c;

   int n_chk = 0, n_fail = 0;
   int exp_g;

   always #10 clk = ~clk;

   vid_clamp_agc dut (
      .clk(clk), .rst_n(rst_n), .luma_smp(luma_smp), .chroma_smp(chroma_smp),
      .clamp_win(clamp_win), .gain_win(gain_win), .vblank(vblank), .agc_en(agc_en),
      .static_gain_y(static_gain_y), .static_gain_c(static_gain_c),
      .clamp_y(clamp_y), .clamp_c(clamp_c), .gain_y(gain_y), .gain_c(gain_c)
   );

   // {clamp_win, vblank, luma, chroma, exp clamp_y, exp clamp_c}
   localparam int NV = 8;
   localparam logic [21:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'd10,  8'd10,  2'b00, 2'b00},   // R2
      {1'b1, 1'b0, 8'd10,  8'd200, 2'b01, 2'b10},   // R3 R4
      {1'b1, 1'b0, 8'd60,  8'd128, 2'b00, 2'b00},   // R3 R4 equal
      {1'b1, 1'b0, 8'd61,  8'd127, 2'b10, 2'b01},   // R3 R4
      {1'b1, 1'b0, 8'd59,  8'd129, 2'b01, 2'b10},   // R3 R4
      {1'b1, 1'b1, 8'd0,   8'd0,   2'b00, 2'b00},   // R2 vblank
      {1'b0, 1'b0, 8'd255, 8'd255, 2'b00, 2'b00},   // R2
      {1'b1, 1'b0, 8'd255, 8'd0,   2'b10, 2'b01}    // R3 R4 extremes
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int nxt(input int g, input int sync, input bit pk);
      if (pk || sync < 15) return (g > 0) ? g - 1 : 0;
      if (sync > 17)       return (g < 511) ? g + 1 : 511;
      return g;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one line: active video (optional full-scale sample), sync window, window close
   task automatic run_line(input int sync, input bit pk, input bit vb, input int g_before);
      @(negedge clk);
      vblank = vb; luma_smp = 8'd100;
      @(negedge clk);
      luma_smp = pk ? 8'd255 : 8'd100;
      @(negedge clk);
      luma_smp = 8'd100;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         gain_win = 1'b1;
         luma_smp = 8'(sync + ((k == 1) ? 0 : (k == 3) ? 1 : k + 2));
      end
      @(posedge clk); #1;
      chk(gain_y == 9'(g_before), "R6 no change before window end", gain_y, g_before);
      @(negedge clk);
      gain_win = 1'b0; luma_smp = 8'd60;
      @(posedge clk); #1;
      @(negedge clk);
      vblank = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state, sampled while reset is held
      repeat (2) @(posedge clk);
      #1;
      chk(clamp_y == 2'b00, "R1 clamp_y", clamp_y, 0);
      chk(clamp_c == 2'b00, "R1 clamp_c", clamp_c, 0);
      chk(gain_y == 9'd256, "R1 gain_y", gain_y, 256);
      @(negedge clk);
      rst_n = 1'b1;

      // clamp vectors
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {clamp_win, vblank, luma_smp, chroma_smp} = VEC[i][21:4];
         @(posedge clk); #1;
         chk(clamp_y == VEC[i][3:2], "R2/R3 clamp_y", clamp_y, VEC[i][3:2]);
         chk(clamp_c == VEC[i][1:0], "R2/R4 clamp_c", clamp_c, VEC[i][1:0]);
      end
      @(negedge clk);
      clamp_win = 1'b0; vblank = 1'b0; luma_smp = 8'd100;
      do_reset();

      // R7: sync level around the target
      exp_g = 256;
      foreach (VEC[i]) ; // keep table in scope
      begin
         int syncs [7] = '{16, 15, 17, 14, 18, 30, 0};
         foreach (syncs[j]) begin
            run_line(syncs[j], 1'b0, 1'b0, exp_g);
            exp_g = nxt(exp_g, syncs[j], 1'b0);
            chk(gain_y == 9'(exp_g), "R7 sync step", gain_y, exp_g);
         end
      end

      // R8: peak overrides a rising sync request
      run_line(30, 1'b1, 1'b0, exp_g);
      exp_g = nxt(exp_g, 30, 1'b1);
      chk(gain_y == 9'(exp_g), "R8 peak decrement", gain_y, exp_g);

      // R9: line in blanking, deep sync and a peak, no effect
      run_line(0, 1'b1, 1'b1, exp_g);
      chk(gain_y == 9'(exp_g), "R9 frozen in vblank", gain_y, exp_g);
      run_line(16, 1'b0, 1'b0, exp_g);
      chk(gain_y == 9'(exp_g), "R9 blanking peak not counted", gain_y, exp_g);

      // R6: chroma gain stays static in automatic mode
      chk(gain_c == 9'd77, "R6 gain_c static", gain_c, 77);

      // R5: static mode and bumpless entry to automatic mode
      @(negedge clk);
      agc_en = 1'b0; static_gain_y = 9'd3; static_gain_c = 9'd200;
      #1;
      chk(gain_y == 9'd3,   "R5 gain_y static", gain_y, 3);
      chk(gain_c == 9'd200, "R5 gain_c static", gain_c, 200);
      run_line(30, 1'b0, 1'b0, 3);
      chk(gain_y == 9'd3, "R5 no loop in static mode", gain_y, 3);
      @(negedge clk);
      agc_en = 1'b1;
      #1;
      chk(gain_y == 9'd3, "R5 automatic starts from static", gain_y, 3);

      // R10: saturation at zero
      exp_g = 3;
      for (int k = 0; k < 5; k++) begin
         run_line(0, 1'b0, 1'b0, exp_g);
         exp_g = nxt(exp_g, 0, 1'b0);
      end
      chk(gain_y == 9'd0, "R10 low saturation", gain_y, 0);

      // R10: saturation at full scale
      @(negedge clk);
      agc_en = 1'b0; static_gain_y = 9'd510;
      @(negedge clk);
      agc_en = 1'b1;
      exp_g = 510;
      for (int k = 0; k < 3; k++) begin
         run_line(100, 1'b0, 1'b0, exp_g);
         exp_g = nxt(exp_g, 100, 1'b0);
      end
      chk(gain_y == 9'd511, "R10 high saturation", gain_y, 511);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule